// File: doc/BRIEF.md
# Boot ROM Overlay and Address Decoder

This block turns the address bus and bus-cycle strobes of a small 8-bit Z80-class processor into one-hot chip selects for the memories and the I/O devices. A boot overlay bit is set whenever the block is reset. While it is set, processor reads from the lower 32 KiB are answered by the boot ROM, so the reset vector at address 0 fetches code from ROM. Writes to the same range still land in RAM, so the boot code can fill RAM underneath itself before it leaves.

Software writes a single control port at I/O address 0Bh. Data bit 0 set to one removes the overlay, and the whole lower half then becomes RAM. Data bit 1 decides whether the 4 KiB video window at the top of memory reaches the character RAM (bit set) or the screen RAM (bit clear). The upper ROM always sits at 8000h–EFFFh. Ports 00h–03h select the parallel I/O device and ports 0Ch–0Fh select the CRT controller. Port decoding looks only at address bits 7:0.

Top module: `memmap_decoder`

## Requirements
- R1: After reset the overlay is on and the character RAM is off: a read of 0000h–7FFFh selects the boot ROM, and an access to F000h–FFFFh selects the screen RAM.
- R2: While the overlay is on, a memory read of 0000h–7FFFh asserts romLoSel and not ramSel. A memory write to that range asserts ramSel and not romLoSel.
- R3: An I/O write to port 0Bh loads the overlay from data bit 0. A one turns the overlay off and a zero turns it back on. The change shows in the clock cycle after the write edge. With the overlay off, every access to 0000h–7FFFh asserts ramSel.
- R4: An I/O write to port 0Bh loads the character RAM enable from data bit 1. While the enable is one, accesses to F000h–FFFFh assert charSel. While it is zero, they assert scrSel.
- R5: Memory accesses to 8000h–EFFFh assert romHiSel in every state and for both reads and writes.
- R6: I/O cycles to ports 00h–03h assert pioSel. The value of address bits 15:8 has no effect on any I/O decode.
- R7: I/O cycles to ports 0Ch–0Fh assert crtcSel. No other port asserts crtcSel or pioSel.
- R8: I/O selects require iorqN low and m1N high. An interrupt acknowledge (iorqN and m1N both low) asserts no select and does not load the control port.
- R9: No memory select is active while mreqN is high. At most one of the seven selects is active at any time.
- R10: A write to any port other than 0Bh, and a read of port 0Bh, leave the overlay and the character RAM enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; the control port loads on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset; turns the overlay on and the character RAM enable off |
| addr | input | 16 | Processor address bus |
| dataIn | input | 8 | Processor data bus; bit 0 and bit 1 are used at port 0Bh |
| mreqN | input | 1 | Active-low memory request |
| iorqN | input | 1 | Active-low I/O request |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| m1N | input | 1 | Active-low opcode-fetch / interrupt-acknowledge marker |
| romLoSel | output | 1 | Boot ROM select (overlay reads of the lower half) |
| ramSel | output | 1 | Main RAM select |
| romHiSel | output | 1 | Upper ROM select, 8000h–EFFFh |
| scrSel | output | 1 | Screen RAM select in the video window |
| charSel | output | 1 | Character RAM select in the video window |
| pioSel | output | 1 | Parallel I/O device select |
| crtcSel | output | 1 | CRT controller select |

## Verification
The assertions assume that mreqN and iorqN are never low together and that rdN and wrN are never low together, as on a real processor bus. The boot-write and one-hot properties would not hold otherwise. The stimulus drives one bus cycle at a time from a task that asserts exactly one request and one direction strobe. It changes inputs on the falling clock edge, so the control port sees stable write data on the rising edge. The memory sweeps cover every 256-byte page in each of the four control states. The port sweeps vary the upper address byte and the state of m1N.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
  // Mapping state handed from the control register to the decoder.
  typedef struct packed {
    logic overlayOn;   // boot ROM shadows reads of the lower half
    logic charEn;      // video window reaches the character RAM
  } mapCtrl_t;

  localparam mapCtrl_t MAP_RESET = '{overlayOn: 1'b1, charEn: 1'b0};
endpackage

// File: rtl/memmap_control.sv
module memmap_control
  import memmap_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OVL_BIT = 0,
  parameter int CHR_BIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic [DATA_W-1:0] dataIn,
  output mapCtrl_t          mapCtrl
);
  mapCtrl_t mapNext;

  always_comb begin
    mapNext = mapCtrl;
    if (ctrlWr) begin
      mapNext.overlayOn = ~dataIn[OVL_BIT];
      mapNext.charEn    = dataIn[CHR_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mapCtrl <= MAP_RESET;
    else       mapCtrl <= mapNext;
  end
endmodule

// File: rtl/memmap_datapath.sv
module memmap_datapath
  import memmap_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                PORT_W     = 8,
  parameter int                BANK_W     = 4,
  parameter int                DEV_SPAN_W = 2,
  parameter logic [PORT_W-1:0] CTRL_PORT  = 8'h0B,
  parameter logic [PORT_W-1:0] PIO_BASE   = 8'h00,
  parameter logic [PORT_W-1:0] CRTC_BASE  = 8'h0C
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              mreqN,
  input  logic              iorqN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              m1N,
  input  mapCtrl_t          mapCtrl,
  output logic              ctrlWr,
  output logic              romLoSel,
  output logic              ramSel,
  output logic              romHiSel,
  output logic              scrSel,
  output logic              charSel,
  output logic              pioSel,
  output logic              crtcSel
);
  localparam int                NUM_DEV  = 2;
  localparam logic [BANK_W-1:0] WIN_BANK = {BANK_W{1'b1}};

  logic [BANK_W-1:0] bank;
  logic [PORT_W-1:0] port;
  logic memCycle, ioCycle, lowHalf, inWindow, bootRead;
  logic [NUM_DEV-1:0] devHit;

  assign bank     = addr[ADDR_W-1 -: BANK_W];
  assign port     = addr[PORT_W-1:0];
  assign memCycle = ~mreqN;
  assign ioCycle  = ~iorqN & m1N;
  assign lowHalf  = ~addr[ADDR_W-1];
  assign inWindow = (bank == WIN_BANK);
  assign bootRead = mapCtrl.overlayOn & ~rdN;

  // Memory map
  assign romLoSel = memCycle & lowHalf & bootRead;
  assign ramSel   = memCycle & lowHalf & ~bootRead;
  assign romHiSel = memCycle & ~lowHalf & ~inWindow;
  assign scrSel   = memCycle & inWindow & ~mapCtrl.charEn;
  assign charSel  = memCycle & inWindow & mapCtrl.charEn;

  // Port decoding: one aligned block of 2**DEV_SPAN_W ports per device
  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    localparam logic [PORT_W-1:0] BASE = (d == 0) ? PIO_BASE : CRTC_BASE;
    assign devHit[d] = ioCycle &
                       (port[PORT_W-1:DEV_SPAN_W] == BASE[PORT_W-1:DEV_SPAN_W]);
  end

  assign pioSel  = devHit[0];
  assign crtcSel = devHit[1];
  assign ctrlWr  = ioCycle & ~wrN & (port == CTRL_PORT);
endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
  import memmap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              mreqN,
  input  logic              iorqN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              m1N,
  output logic              romLoSel,
  output logic              ramSel,
  output logic              romHiSel,
  output logic              scrSel,
  output logic              charSel,
  output logic              pioSel,
  output logic              crtcSel
);
  mapCtrl_t mapCtrl;
  logic     ctrlWr;

  memmap_control #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .dataIn(dataIn), .mapCtrl(mapCtrl)
  );

  memmap_datapath #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_dp (
    .addr(addr), .mreqN(mreqN), .iorqN(iorqN), .rdN(rdN), .wrN(wrN), .m1N(m1N),
    .mapCtrl(mapCtrl), .ctrlWr(ctrlWr),
    .romLoSel(romLoSel), .ramSel(ramSel), .romHiSel(romHiSel),
    .scrSel(scrSel), .charSel(charSel), .pioSel(pioSel), .crtcSel(crtcSel)
  );
endmodule

// File: rtl/memmap_decoder_check.sv
module memmap_decoder_check (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] addr,
  input logic [7:0]  dataIn,
  input logic        mreqN,
  input logic        iorqN,
  input logic        rdN,
  input logic        wrN,
  input logic        m1N,
  input logic        romLoSel,
  input logic        ramSel,
  input logic        romHiSel,
  input logic        scrSel,
  input logic        charSel,
  input logic        pioSel,
  input logic        crtcSel
);
  logic anyMem;
  assign anyMem = romLoSel | ramSel | romHiSel | scrSel | charSel;

  assert_mem_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    mreqN |-> !anyMem);

  assert_one_sel_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({romLoSel, ramSel, romHiSel, scrSel, charSel, pioSel, crtcSel}));

  assert_io_qual_R8: assert property (@(posedge clk) disable iff (!rstN)
    (iorqN || !m1N) |-> !(pioSel || crtcSel));

  assert_boot_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!mreqN && !wrN && rdN && !addr[15]) |-> (ramSel && !romLoSel));

  assert_overlay_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!iorqN && m1N && !wrN && addr[7:0] == 8'h0B && dataIn[0]) |=> !romLoSel);

  assert_upper_rom_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!mreqN && addr[15] && addr[15:12] != 4'hF) |-> romHiSel);

  assert_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!mreqN && addr[15:12] == 4'hF) |-> (scrSel || charSel));

  assert_crtc_ports_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!iorqN && m1N && addr[7:2] == 6'h03) |-> crtcSel);
endmodule

bind memmap_decoder memmap_decoder_check u_check (
  .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn),
  .mreqN(mreqN), .iorqN(iorqN), .rdN(rdN), .wrN(wrN), .m1N(m1N),
  .romLoSel(romLoSel), .ramSel(ramSel), .romHiSel(romHiSel),
  .scrSel(scrSel), .charSel(charSel), .pioSel(pioSel), .crtcSel(crtcSel)
);

// File: tb/memmap_decoder_test.sv
module memmap_decoder_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  dataIn = '0;
  logic        mreqN = 1'b1, iorqN = 1'b1, rdN = 1'b1, wrN = 1'b1, m1N = 1'b1;
  logic        romLoSel, ramSel, romHiSel, scrSel, charSel, pioSel, crtcSel;

  int checks = 0;
  int errors = 0;
  bit expOverlay = 1'b1;
  bit expChar = 1'b0;

  always #4 clk = ~clk;

  memmap_decoder uut (
    .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn),
    .mreqN(mreqN), .iorqN(iorqN), .rdN(rdN), .wrN(wrN), .m1N(m1N),
    .romLoSel(romLoSel), .ramSel(ramSel), .romHiSel(romHiSel),
    .scrSel(scrSel), .charSel(charSel), .pioSel(pioSel), .crtcSel(crtcSel)
  );

  // Select vector order: romLo, ram, romHi, scr, char, pio, crtc
  function automatic logic [6:0] memExp(input logic [15:0] a, input bit isRd);
    logic [6:0] e = '0;
    if (a[15] == 1'b0) begin
      if (expOverlay && isRd) e[6] = 1'b1; else e[5] = 1'b1;
    end else if (a[15:12] != 4'hF) e[4] = 1'b1;
    else if (expChar) e[2] = 1'b1;
    else e[3] = 1'b1;
    return e;
  endfunction

  function automatic logic [6:0] ioExp(input logic [7:0] p, input bit ack);
    logic [6:0] e = '0;
    if (!ack) begin
      if (p <= 8'h03) e[1] = 1'b1;
      if (p >= 8'h0C && p <= 8'h0F) e[0] = 1'b1;
    end
    return e;
  endfunction

  task automatic check(input string tag, input logic [6:0] exp);
    logic [6:0] act = {romLoSel, ramSel, romHiSel, scrSel, charSel, pioSel, crtcSel};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%b expected=%b", tag, addr, act, exp);
    end
  endtask

  task automatic idle();
    mreqN = 1'b1; iorqN = 1'b1; rdN = 1'b1; wrN = 1'b1; m1N = 1'b1;
  endtask

  task automatic memCycle(input logic [15:0] a, input bit isRd, input string tag);
    @(negedge clk);
    addr = a; mreqN = 1'b0; rdN = ~isRd; wrN = isRd;
    #1 check(tag, memExp(a, isRd));
    @(negedge clk); idle();
  endtask

  task automatic ioCycle(input logic [15:0] a, input logic [7:0] d, input bit isWr,
                         input bit ack, input string tag);
    @(negedge clk);
    addr = a; dataIn = d; iorqN = 1'b0; m1N = ~ack;
    rdN = isWr; wrN = ~isWr;
    if (ack) begin rdN = 1'b1; wrN = 1'b1; end
    #1 check(tag, ioExp(a[7:0], ack));
    @(posedge clk);
    if (isWr && !ack && a[7:0] == 8'h0B) begin
      expOverlay = ~d[0]; expChar = d[1];
    end
    @(negedge clk); idle();
  endtask

  task automatic memSweep(input string stateTag);
    for (int p = 0; p < 256; p++) begin
      logic [15:0] a = {p[7:0], p[7:0]};
      string tag = (a[15] == 1'b0) ? (expOverlay ? "R2" : "R3")
                 : (a[15:12] != 4'hF) ? "R5" : "R4";
      memCycle(a, 1'b1, {tag, " read ", stateTag});
      memCycle(a, 1'b0, {tag, " write ", stateTag});
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    // R9: no memory request, nothing selected
    #1 check("R9 idle", 7'b0);
    @(negedge clk); rstN = 1'b1;
    // R1: reset state
    memCycle(16'h0000, 1'b1, "R1 reset boot read");
    memCycle(16'hF123, 1'b1, "R1 reset window");
    memSweep("overlay on chr off");

    // Four control states: bit0 overlay off, bit1 character RAM on
    for (int s = 1; s < 4; s++) begin
      ioCycle(16'h000B, s[7:0], 1'b1, 1'b0, "R3 R4 ctrl write");
      memSweep($sformatf("state %0d", s));
    end
    // R3: bit0 = 0 restores the overlay
    ioCycle(16'h770B, 8'h00, 1'b1, 1'b0, "R3 ctrl write");
    memCycle(16'h1234, 1'b1, "R3 overlay restored");
    memCycle(16'hFABC, 1'b1, "R4 char off");

    // R6 R7: port sweep with varied upper byte, reads and writes
    for (int h = 0; h < 3; h++) begin
      logic [7:0] hi = (h == 0) ? 8'h00 : (h == 1) ? 8'h5A : 8'hFF;
      for (int p = 0; p < 256; p++) begin
        if (p != 8'h0B) begin
          ioCycle({hi, p[7:0]}, 8'h03, h[0], 1'b0,
                  (p < 4) ? "R6 pio port" : "R7 crtc port");
        end
      end
    end
    // R10: writes above to other ports left overlay on, character RAM off
    memCycle(16'h0100, 1'b1, "R10 other ports overlay");
    memCycle(16'hF000, 1'b0, "R10 other ports window");

    // R10: read of port 0Bh leaves state
    ioCycle(16'h000B, 8'h03, 1'b0, 1'b0, "R10 ctrl read");
    memCycle(16'h0200, 1'b1, "R10 read no effect");
    memCycle(16'hFFFF, 1'b1, "R10 read no effect window");

    // R8: interrupt acknowledge selects nothing and loads nothing
    for (int p = 0; p < 16; p++)
      ioCycle({8'h00, p[7:0]}, 8'h03, 1'b1, 1'b1, "R8 int ack");
    memCycle(16'h0300, 1'b1, "R8 ack no load");
    memCycle(16'hF800, 1'b1, "R8 ack no load window");

    // R9: memory request combined with port-like address: only memory select
    memCycle(16'h000C, 1'b1, "R9 mem not io");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule